// File: doc/BRIEF.md
# Single-Wire Serial-ID Responder

This block is the slave side of a single-wire, open-drain identification bus. It runs from a free-running local clock and watches the shared line. A master starts a transaction by holding the line low for a long time. The block answers that reset pulse with a presence pulse, then takes in an 8-bit command through write slots. If the command asks for the ROM, the block returns a 64-bit identifier, one bit in each read slot that the master starts.

All slot timings are set in microseconds and are turned into clock cycles through a cycles-per-microsecond parameter. The single output is an output-enable-bar for the pad: 0 pulls the wire low and 1 releases it to the pull-up. A busy flag tells neighbouring logic that shares the pin when a transaction is in progress. The line input passes through a two-stage synchronizer, and every cycle count below is measured on the synchronized value.

Notation: C_RST, C_PD, C_PL, C_SMP and C_RLOW are the reset, presence-delay, presence-low, write-sample and read-hold times multiplied by CLK_PER_US. "Edge n" is a rising clock edge that samples line_i. "After edge n" means the value the outputs hold from that edge until the next one.

Top module: `owid_slave`

## Requirements
- R1: While rst_n is low, and afterwards until a reset pulse is recognized, line_oeb is 1 and busy is 0.
- R2: A low that line_i shows on C_RST consecutive edges k .. k+C_RST-1 is a reset pulse, and busy is 1 after edge k+C_RST+2. A shorter low has no effect: busy stays 0 and no presence pulse follows.
- R3: After a reset pulse, let r be the first edge that samples the line high. line_oeb is 0 after edges r+2+C_PD through r+1+C_PD+C_PL, and 1 during the rest of that window.
- R4: A write slot begins at the first edge f that samples the line low after it was high. The command bit is the line level at edge f+C_SMP. The first slot carries bit 0, so the command arrives LSB first.
- R5: Command 0x33 starts the readout. The read slot that begins at edge f sends ROM bit i, taken from rom_word[i] with bit 0 first. A 0 bit drives line_oeb to 0 after edges f+2 through f+1+C_RLOW. A 1 bit leaves the line released.
- R6: Any other command value, 0xCC for example, drops busy after edge f+2+C_SMP of the eighth write slot. Later slots that start while the block is idle get no response.
- R7: busy is 1 from the recognized reset pulse until the transaction ends (R6, R9) and 0 at every other time.
- R8: A reset pulse in any state aborts that state and restarts the presence sequence of R3. This includes a pulse whose falling edge started the read slot of a 0 bit: that slot's drive still lasts its normal C_RLOW cycles, and busy stays 1 throughout.
- R9: After the 64th read slot, busy is 0 after edge f+2+C_RLOW and the line stays released.
- R10: Transactions run back to back, and each one returns the rom_word value present during its own readout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Level of the shared single-wire line |
| rom_word | input | 64 | Identifier returned by the readout, bit 0 sent first |
| line_oeb | output | 1 | Pad output-enable-bar: 0 pulls the line low, 1 releases it |
| busy | output | 1 | High whenever the state machine is not idle |

## Verification
Two of the block's functions can act in the same cycle: its own read-0 drive and the low-duration timer that recognizes a reset pulse. To provoke this, the master opens a read slot on a bit known to be 0 and keeps holding the line long enough to form a reset pulse. The slave therefore pulls low while its low timer is already counting toward the reset threshold. The result is judged cycle by cycle against the bench model: the slot drive must last exactly its normal length, busy must never drop, and the presence pulse must start at the count set by the master's release. A fresh full readout must then succeed.

// File: rtl/owid_pkg.sv
package owid_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RSTLOW,
    ST_PDLY,
    ST_PLOW,
    ST_CMD,
    ST_ROM
  } owid_state_e;

  localparam logic [7:0] CMD_READ_ROM = 8'h33;

  // microsecond figure to clock cycles
  function automatic int unsigned us2cyc(input int unsigned us, input int unsigned cyc_per_us);
    return us * cyc_per_us;
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/owid_sync.sv
module owid_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_s,
  output logic fall
);
  logic [STAGES-1:0] sr;
  logic              line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '1;
      line_q <= 1'b1;
    end else begin
      sr     <= {sr[STAGES-2:0], line_i};
      line_q <= sr[STAGES-1];
    end
  end

  assign line_s = sr[STAGES-1];
  assign fall   = line_q & ~line_s;
endmodule

// File: rtl/owid_lowtimer.sv
module owid_lowtimer #(
  parameter int RST_CYC = 48000,
  localparam int W = $clog2(RST_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_s,
  output logic long_low,
  output logic rel_evt
);
  logic [W-1:0] lowcnt;

  assign long_low = (lowcnt == W'(RST_CYC));
  assign rel_evt  = long_low & line_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lowcnt <= '0;
    else if (line_s)   lowcnt <= '0;
    else if (!long_low) lowcnt <= lowcnt + W'(1);
  end

  AST_LOWCNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    lowcnt <= W'(RST_CYC)); // R2
endmodule

// File: rtl/owid_fsm.sv
module owid_fsm
  import owid_pkg::*;
#(
  parameter int PD_CYC   = 1500,
  parameter int PL_CYC   = 12000,
  parameter int SMP_CYC  = 3000,
  parameter int RLOW_CYC = 3000,
  localparam int MAXC = int'(max4(PD_CYC, PL_CYC, SMP_CYC, RLOW_CYC)),
  localparam int CW   = $clog2(MAXC + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_s,
  input  logic        fall,
  input  logic        long_low,
  input  logic        rel_evt,
  input  logic [63:0] rom_word,
  output logic        line_oeb,
  output logic        busy
);
  owid_state_e   state;
  logic [CW-1:0] cnt;
  logic [5:0]    bitn;
  logic [7:0]    shreg;
  logic          in_slot;

  logic [CW-1:0] lim;
  logic          slot_end;
  logic [7:0]    cmd_next;
  logic          drv;

  assign lim      = (state == ST_CMD) ? CW'(SMP_CYC - 1) : CW'(RLOW_CYC - 1);
  assign slot_end = in_slot && (cnt == lim);
  assign cmd_next = {line_s, shreg[7:1]};
  assign drv      = (state == ST_PLOW) ||
                    (state == ST_ROM && in_slot && !rom_word[bitn]);
  assign line_oeb = ~drv;
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bitn    <= '0;
      shreg   <= '0;
      in_slot <= 1'b0;
    end else if (rel_evt) begin
      state   <= ST_PDLY;
      cnt     <= '0;
      bitn    <= '0;
      in_slot <= 1'b0;
    end else if (long_low) begin
      state   <= ST_RSTLOW;
      cnt     <= '0;
      in_slot <= 1'b0;
    end else begin
      case (state)
        ST_PDLY: begin
          if (cnt == CW'(PD_CYC - 1)) begin
            state <= ST_PLOW;
            cnt   <= '0;
          end else cnt <= cnt + CW'(1);
        end
        ST_PLOW: begin
          if (cnt == CW'(PL_CYC - 1)) begin
            state   <= ST_CMD;
            cnt     <= '0;
            bitn    <= '0;
            in_slot <= 1'b0;
          end else cnt <= cnt + CW'(1);
        end
        ST_CMD: begin
          if (!in_slot) begin
            if (fall) begin
              in_slot <= 1'b1;
              cnt     <= '0;
            end
          end else if (slot_end) begin
            shreg   <= cmd_next;
            in_slot <= 1'b0;
            if (bitn == 6'd7) begin
              bitn  <= '0;
              state <= (cmd_next == CMD_READ_ROM) ? ST_ROM : ST_IDLE;
            end else bitn <= bitn + 6'd1;
          end else cnt <= cnt + CW'(1);
        end
        ST_ROM: begin
          if (!in_slot) begin
            if (fall) begin
              in_slot <= 1'b1;
              cnt     <= '0;
            end
          end else if (slot_end) begin
            in_slot <= 1'b0;
            if (bitn == 6'd63) begin
              bitn  <= '0;
              state <= ST_IDLE;
            end else bitn <= bitn + 6'd1;
          end else cnt <= cnt + CW'(1);
        end
        default: ;
      endcase
    end
  end

  AST_REL_TO_PDLY: assert property (@(posedge clk) disable iff (!rst_n)
    rel_evt |=> state == ST_PDLY); // R3
  AST_PRES_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_PLOW |-> cnt < CW'(PL_CYC)); // R3
  AST_CMD_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_CMD |-> bitn < 6'd8); // R4
  AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (long_low && !line_s) |=> state == ST_RSTLOW); // R8
  AST_CMD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CMD && slot_end && bitn == 6'd7 && cmd_next != CMD_READ_ROM && !long_low)
      |=> state == ST_IDLE); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ROM && slot_end && bitn == 6'd63 && !long_low)
      |=> (state == ST_IDLE && line_oeb)); // R9
endmodule

// File: rtl/owid_slave.sv
module owid_slave
  import owid_pkg::*;
#(
  parameter int CLK_PER_US   = 100,
  parameter int RST_MIN_US   = 480,
  parameter int PRES_WAIT_US = 15,
  parameter int PRES_LOW_US  = 120,
  parameter int WR_SAMPLE_US = 30,
  parameter int RD_HOLD_US   = 30,
  parameter int SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_i,
  input  logic [63:0] rom_word,
  output logic        line_oeb,
  output logic        busy
);
  localparam int RST_CYC  = int'(us2cyc(RST_MIN_US,   CLK_PER_US));
  localparam int PD_CYC   = int'(us2cyc(PRES_WAIT_US, CLK_PER_US));
  localparam int PL_CYC   = int'(us2cyc(PRES_LOW_US,  CLK_PER_US));
  localparam int SMP_CYC  = int'(us2cyc(WR_SAMPLE_US, CLK_PER_US));
  localparam int RLOW_CYC = int'(us2cyc(RD_HOLD_US,   CLK_PER_US));

  logic line_s, fall, long_low, rel_evt;

  owid_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .line_s(line_s), .fall(fall)
  );

  owid_lowtimer #(.RST_CYC(RST_CYC)) u_lowtimer (
    .clk(clk), .rst_n(rst_n), .line_s(line_s), .long_low(long_low), .rel_evt(rel_evt)
  );

  owid_fsm #(
    .PD_CYC(PD_CYC), .PL_CYC(PL_CYC), .SMP_CYC(SMP_CYC), .RLOW_CYC(RLOW_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .line_s(line_s), .fall(fall),
    .long_low(long_low), .rel_evt(rel_evt), .rom_word(rom_word),
    .line_oeb(line_oeb), .busy(busy)
  );
endmodule

// File: tb/owid_slave_tb.sv
module owid_slave_tb;
  localparam int CPU     = 2;
  localparam int RST_US  = 20;
  localparam int PD_US   = 3;
  localparam int PL_US   = 6;
  localparam int SMP_US  = 4;
  localparam int RLOW_US = 5;
  localparam int C_RST   = RST_US * CPU;
  localparam int C_PD    = PD_US * CPU;
  localparam int C_PL    = PL_US * CPU;
  localparam int C_SMP   = SMP_US * CPU;
  localparam int C_RLOW  = RLOW_US * CPU;
  localparam int BIG     = 1 << 30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_low = 1'b0;
  logic        line_i;
  logic [63:0] rom_word = 64'hA5C3_0F1E_2D3C_4B5A;
  logic        line_oeb, busy;

  int    cyc = 0;
  int    vectors = 0;
  int    miscomp = 0;
  int    lo_s[$];
  int    lo_e[$];
  int    bz_on = BIG;
  int    bz_off = BIG;
  string tag = "R1";
  bit    chk_on = 1'b0;
  logic  e_oeb, e_busy;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign line_i = ~m_low & line_oeb;

  owid_slave #(
    .CLK_PER_US(CPU), .RST_MIN_US(RST_US), .PRES_WAIT_US(PD_US),
    .PRES_LOW_US(PL_US), .WR_SAMPLE_US(SMP_US), .RD_HOLD_US(RLOW_US)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .rom_word(rom_word),
    .line_oeb(line_oeb), .busy(busy)
  );

  // Reference model: expected outputs from scheduled windows, checked every cycle
  always @(negedge clk) begin
    if (chk_on) begin
      e_oeb = 1'b1;
      foreach (lo_s[i]) if (cyc >= lo_s[i] && cyc < lo_e[i]) e_oeb = 1'b0;
      e_busy = (cyc >= bz_on && cyc < bz_off);
      vectors++;
      if (line_oeb !== e_oeb || busy !== e_busy) begin
        miscomp++;
        $display("FAIL %s (R7 busy) cyc=%0d oeb act %b exp %b busy act %b exp %b",
                 tag, cyc, line_oeb, e_oeb, busy, e_busy);
      end
    end
  end

  task automatic check_bit(input string t, input bit got, input bit exp_v);
    vectors++;
    if (got !== exp_v) begin
      miscomp++;
      $display("FAIL %s read bit act %b exp %b at cyc %0d", t, got, exp_v, cyc);
    end
  endtask

  task automatic pulse_reset(input int hold, input bit det, input bit slot0, input string t);
    int a0;
    @(negedge clk);
    a0 = cyc; tag = t; m_low = 1'b1;
    if (slot0) begin lo_s.push_back(a0 + 3); lo_e.push_back(a0 + 3 + C_RLOW); end
    if (det && !(a0 + 1 >= bz_on && a0 + 1 < bz_off)) bz_on = a0 + 3 + C_RST;
    if (det) bz_off = BIG;
    repeat (hold - 1) @(negedge clk);
    @(negedge clk);
    m_low = 1'b0;
    if (det) begin lo_s.push_back(cyc + 3 + C_PD); lo_e.push_back(cyc + 3 + C_PD + C_PL); end
    repeat (C_PD + C_PL + 12) @(negedge clk);
  endtask

  task automatic write_bit(input bit v, input bit last_rej);
    int b, hold;
    @(negedge clk);
    b = cyc; m_low = 1'b1;
    hold = v ? 2 : C_SMP + 4;
    if (last_rej) bz_off = b + 3 + C_SMP;
    repeat (hold - 1) @(negedge clk);
    @(negedge clk);
    m_low = 1'b0;
    repeat (30 - hold - 1) @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] v, input bit rej, input string t);
    tag = t;
    for (int i = 0; i < 8; i++) write_bit(v[i], rej && i == 7);
  endtask

  task automatic read_bit(input bit ev, input bit active, input bit last, output bit got);
    int b;
    @(negedge clk);
    b = cyc; m_low = 1'b1;
    if (active && !ev) begin lo_s.push_back(b + 3); lo_e.push_back(b + 3 + C_RLOW); end
    if (last) bz_off = b + 3 + C_RLOW;
    repeat (2) @(negedge clk);
    @(negedge clk);
    m_low = 1'b0;
    repeat (3) @(negedge clk);
    got = line_i;
    repeat (14) @(negedge clk);
  endtask

  task automatic read_rom(input string t);
    bit g;
    tag = t;
    for (int i = 0; i < 64; i++) begin
      read_bit(rom_word[i], 1'b1, i == 63, g);
      check_bit(t, g, rom_word[i]);
    end
  endtask

  initial begin
    bit g;
    int idx;
    repeat (2) @(negedge clk);
    chk_on = 1'b1;                       // R1: reset state checked per cycle
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    pulse_reset(30, 1'b0, 1'b0, "R2");   // short low ignored
    repeat (20) @(negedge clk);

    pulse_reset(45, 1'b1, 1'b0, "R3");   // presence timing
    write_byte(8'h33, 1'b0, "R4");
    read_rom("R5");                      // ends per R9
    tag = "R9";
    repeat (20) @(negedge clk);

    pulse_reset(C_RST, 1'b1, 1'b0, "R2");
    write_byte(8'hCC, 1'b1, "R6");       // reversed order: rejected
    tag = "R6";
    for (int i = 0; i < 3; i++) begin
      read_bit(1'b1, 1'b0, 1'b0, g);
      check_bit("R6", g, 1'b1);
    end

    rom_word = 64'h0123_4567_89AB_CDEF;
    pulse_reset(42, 1'b1, 1'b0, "R10");
    write_byte(8'h33, 1'b0, "R10");
    read_rom("R10");
    repeat (10) @(negedge clk);

    // R8: reset pulse that begins as a read slot of a 0 bit
    pulse_reset(45, 1'b1, 1'b0, "R8");
    write_byte(8'h33, 1'b0, "R8");
    idx = 0;
    while (idx < 10 || rom_word[idx] != 1'b0) begin
      read_bit(rom_word[idx], 1'b1, 1'b0, g);
      check_bit("R8", g, rom_word[idx]);
      idx++;
    end
    pulse_reset(50, 1'b1, 1'b1, "R8");
    write_byte(8'h33, 1'b0, "R8");
    read_rom("R8");
    repeat (20) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscomp++;
    $display("FAIL watchdog expired at cyc %0d", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end
endmodule